// File: doc/BRIEF.md
# Triggered Logic Acquisition Controller

This block records a parallel bus of digital probe inputs into an on-chip sample buffer so that a host can read the record afterwards. Each sample point is marked by a one-cycle sample enable, which comes either from a synchronized external sample clock or from an internal divider of the system clock. The divider offers a menu of eight rates. Acquisition runs while stimulus is being applied to the circuit under test, so the probes see that circuit's responses live.

The host programs a small set of configuration registers while the block is idle. It then pulses `arm`. The block waits for the selected trigger condition, stores the sample at the trigger point as the first entry, and keeps storing until the programmed number of samples is held. The host then pulls the samples out in capture order, one per read strobe. `abort` returns the block to idle at any time.

Register map, written through `cfg_we`, `cfg_addr` and `cfg_wdata`:
- Address 0 is the control register. Bits [2:0] hold the rate code, bit 3 selects the external sample clock when set, and bits [5:4] hold the trigger mode.
- Address 1 holds the trigger word.
- Address 2 holds the trigger mask.
- Address 3 holds the capture length.

Reset values are: rate code 7, internal strobe, clock trigger, word 0, mask 0, length 1.

Top module: `la_acq_top`

## Requirements
- R1: Control bit 3 selects the sample source. With the bit at 1, each rising edge of `ext_sclk` yields exactly one sample and the internal divider has no effect. With the bit at 0, only the internal divider yields samples.
- R2: With the internal source, rate codes 0 to 7 give sample periods of 2000, 1000, 500, 200, 100, 50, 10 and 5 system clocks, in that order (25 kHz to 10 MHz at 50 MHz).
- R3: A capture stores exactly N samples and then enters DONE. N is the length register value, except that 0 is taken as 1 and any value above 2048 is taken as 2048.
- R4: Trigger mode 0 (clock) starts capture on the first sample point after arming.
- R5: Trigger mode 1 (external) starts capture on the first sample point at or after a synchronized rising edge of `ext_trig` that is seen while armed.
- R6: Trigger mode 2 (word) starts capture on the first sample point where (probe & mask) == (word & mask).
- R7: Trigger mode 3 (key) starts capture on the first sample point at or after a press of `key_in`. A press counts only once the input has been high for `DEBOUNCE_CYCLES` consecutive clocks, so shorter pulses never trigger.
- R8: `phase` reports IDLE=0, ARMED=1, CAPTURE=2 and DONE=3. Reset gives IDLE. `arm` moves IDLE to ARMED and has no effect in any other state. The triggering sample is stored as sample 0.
- R9: `abort` returns the block to IDLE on the next clock from any state.
- R10: In DONE, each `rd_stb` pulse returns the next stored sample in capture order on `rd_data`, with `rd_valid` high for one cycle, one clock after the strobe. Strobes beyond the stored count, or outside DONE, give no `rd_valid`.
- R11: Configuration writes take effect only in IDLE. Writes in any other state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| arm | input | 1 | Arm pulse, acted on in IDLE |
| abort | input | 1 | Return to IDLE |
| probe | input | DATA_W | Probe bus being recorded |
| ext_sclk | input | 1 | External sample clock, below a quarter of clk |
| ext_trig | input | 1 | External trigger input |
| key_in | input | 1 | Push-button input, high when pressed |
| rd_stb | input | 1 | Read strobe for buffer readout |
| phase | output | 2 | Controller state |
| rd_data | output | DATA_W | Sample returned by a read |
| rd_valid | output | 1 | One-cycle qualifier for rd_data |

## Verification
The hardest case to reach is the capture that fills the whole 2048-entry buffer. It needs a length above the limit, a long run at the fastest internal rate and a full readout. The bench programs 3000, captures from a probe bus that advances every clock, and confirms that exactly 2048 samples come back, each five clocks after the one before. Debounce rejection is also awkward to reach. The bench applies a key pulse shorter than the debounce window, checks that the controller stays armed, and then holds a real press and checks the time of the first stored sample.

// File: rtl/la_pkg.sv
package la_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } la_state_e;

    typedef enum logic [1:0] {
        TRG_CLOCK = 2'd0,
        TRG_EXT   = 2'd1,
        TRG_WORD  = 2'd2,
        TRG_KEY   = 2'd3
    } la_trig_e;

    localparam int RATE_W = 3;
    localparam int DIV_W  = 11;

    // control register layout, low six bits of a write to address 0
    typedef struct packed {
        la_trig_e          mode;
        logic              ext_clk;
        logic [RATE_W-1:0] rate;
    } la_ctrl_t;

    localparam la_ctrl_t CTRL_RESET = '{mode: TRG_CLOCK, ext_clk: 1'b0, rate: 3'd7};

    // system clocks per internal sample, slowest code first
    function automatic logic [DIV_W-1:0] rate_divisor(input logic [RATE_W-1:0] code);
        case (code)
            3'd0:    return 11'd2000;
            3'd1:    return 11'd1000;
            3'd2:    return 11'd500;
            3'd3:    return 11'd200;
            3'd4:    return 11'd100;
            3'd5:    return 11'd50;
            3'd6:    return 11'd10;
            default: return 11'd5;
        endcase
    endfunction

    function automatic int unsigned clamp_len(input int unsigned raw, input int unsigned depth);
        if (raw == 0) return 1;
        if (raw > depth) return depth;
        return raw;
    endfunction

endpackage

// File: rtl/la_strobe_gen.sv
module la_strobe_gen
    import la_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              use_ext,
    input  logic              ext_sclk,
    output logic              sample_en
);
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] cnt_q;
    logic             int_tick;
    logic [2:0]       sync_q;
    logic             ext_tick;

    assign div = rate_divisor(rate_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q >= div - DIV_W'(1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign int_tick = (cnt_q == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], ext_sclk};
    end

    assign ext_tick  = sync_q[1] & ~sync_q[2];
    assign sample_en = use_ext ? ext_tick : int_tick;

    // shortest divisor is 5, so internal ticks never come back to back
    p_int_gap_r2: assert property (@(posedge clk) disable iff (rst)
        int_tick |=> !int_tick);

endmodule

// File: rtl/la_trigger.sv
module la_trigger
    import la_pkg::*;
#(
    parameter int DATA_W          = 16,
    parameter int DEBOUNCE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  la_trig_e          mode,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] probe,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] mask,
    input  logic              ext_trig,
    input  logic              key_in,
    output logic              fire
);
    localparam int DEB_W = $clog2(DEBOUNCE_CYCLES + 1);

    logic [2:0]       trg_sync_q;
    logic             ext_edge;
    logic [1:0]       key_sync_q;
    logic             key_level_q;
    logic [DEB_W-1:0] deb_cnt_q;
    logic             key_press;
    logic             event_now;
    logic             pend_q;
    logic             word_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            trg_sync_q <= '0;
            key_sync_q <= '0;
        end else begin
            trg_sync_q <= {trg_sync_q[1:0], ext_trig};
            key_sync_q <= {key_sync_q[0], key_in};
        end
    end

    assign ext_edge  = trg_sync_q[1] & ~trg_sync_q[2];
    assign key_press = key_sync_q[1] & ~key_level_q
                     & (deb_cnt_q == DEB_W'(DEBOUNCE_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            key_level_q <= 1'b0;
            deb_cnt_q   <= '0;
        end else if (key_sync_q[1] == key_level_q) begin
            deb_cnt_q <= '0;
        end else if (deb_cnt_q == DEB_W'(DEBOUNCE_CYCLES - 1)) begin
            key_level_q <= key_sync_q[1];
            deb_cnt_q   <= '0;
        end else begin
            deb_cnt_q <= deb_cnt_q + DEB_W'(1);
        end
    end

    always_comb begin
        case (mode)
            TRG_EXT: event_now = ext_edge;
            TRG_KEY: event_now = key_press;
            default: event_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !armed) pend_q <= 1'b0;
        else if (event_now) pend_q <= 1'b1;
    end

    assign word_hit = (((probe ^ word) & mask) == '0);

    always_comb begin
        case (mode)
            TRG_CLOCK: fire = armed & sample_en;
            TRG_WORD:  fire = armed & sample_en & word_hit;
            default:   fire = armed & sample_en & (pend_q | event_now);
        endcase
    end

    // the debounced level only rises after the raw level was high
    p_key_settled_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(key_level_q) |-> $past(key_sync_q[1]));

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
    import la_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        arm,
    input  logic                        abort,
    input  logic                        sample_en,
    input  logic                        fire,
    input  logic [DATA_W-1:0]           probe,
    input  logic [$clog2(DEPTH):0]      eff_len,
    input  logic                        rd_stb,
    output la_state_e                   state,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_valid
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    la_state_e         state_q;
    logic [CNT_W-1:0]  wr_cnt_q;
    logic [CNT_W-1:0]  rd_cnt_q;
    logic              rd_valid_q;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] buf_mem [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    assign wr_en = !abort && (((state_q == ST_ARMED) && fire)
                           || ((state_q == ST_CAPTURE) && sample_en));
    assign rd_en = !abort && (state_q == ST_DONE) && rd_stb && (rd_cnt_q < eff_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            wr_cnt_q   <= '0;
            rd_cnt_q   <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (abort) begin
                state_q  <= ST_IDLE;
                wr_cnt_q <= '0;
                rd_cnt_q <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: if (arm) begin
                        state_q  <= ST_ARMED;
                        wr_cnt_q <= '0;
                        rd_cnt_q <= '0;
                    end
                    ST_ARMED: if (fire) begin
                        wr_cnt_q <= CNT_W'(1);
                        state_q  <= (eff_len == CNT_W'(1)) ? ST_DONE : ST_CAPTURE;
                    end
                    ST_CAPTURE: if (sample_en) begin
                        wr_cnt_q <= wr_cnt_q + CNT_W'(1);
                        if (wr_cnt_q == eff_len - CNT_W'(1)) state_q <= ST_DONE;
                    end
                    default: if (rd_en) rd_cnt_q <= rd_cnt_q + CNT_W'(1);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) buf_mem[wr_cnt_q[ADDR_W-1:0]] <= probe;
        if (rd_en) rd_data_q <= buf_mem[rd_cnt_q[ADDR_W-1:0]];
    end

    assign state    = state_q;
    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
        abort |=> state_q == ST_IDLE);

    p_arm_enter_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && arm && !abort) |=> state_q == ST_ARMED);

    p_wr_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE) |-> (wr_cnt_q < eff_len));

    p_read_in_done_r10: assert property (@(posedge clk) disable iff (rst)
        rd_valid_q |-> $past(state_q) == ST_DONE);

    p_wait_sample_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && !sample_en && !abort) |=> state_q == ST_ARMED);

endmodule

// File: rtl/la_acq_top.sv
module la_acq_top
    import la_pkg::*;
#(
    parameter int DATA_W          = 16,
    parameter int DEPTH           = 2048,
    parameter int DEBOUNCE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              arm,
    input  logic              abort,
    input  logic [DATA_W-1:0] probe,
    input  logic              ext_sclk,
    input  logic              ext_trig,
    input  logic              key_in,
    input  logic              rd_stb,
    output logic [1:0]        phase,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LEN_W = $clog2(DEPTH) + 1;

    la_ctrl_t          ctrl_q;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] mask_q;
    logic [LEN_W-1:0]  len_q;
    la_state_e         state;
    logic              sample_en;
    logic              fire;
    logic              cfg_open;

    assign cfg_open = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            word_q <= '0;
            mask_q <= '0;
            len_q  <= LEN_W'(1);
        end else if (cfg_we && cfg_open) begin
            case (cfg_addr)
                2'd0:    ctrl_q <= la_ctrl_t'(cfg_wdata[5:0]);
                2'd1:    word_q <= cfg_wdata;
                2'd2:    mask_q <= cfg_wdata;
                default: len_q  <= LEN_W'(clamp_len(32'(cfg_wdata), DEPTH));
            endcase
        end
    end

    la_strobe_gen i_strobe (
        .clk       (clk),
        .rst       (rst),
        .rate_code (ctrl_q.rate),
        .use_ext   (ctrl_q.ext_clk),
        .ext_sclk  (ext_sclk),
        .sample_en (sample_en)
    );

    la_trigger #(
        .DATA_W          (DATA_W),
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) i_trigger (
        .clk       (clk),
        .rst       (rst),
        .armed     (state == ST_ARMED),
        .mode      (ctrl_q.mode),
        .sample_en (sample_en),
        .probe     (probe),
        .word      (word_q),
        .mask      (mask_q),
        .ext_trig  (ext_trig),
        .key_in    (key_in),
        .fire      (fire)
    );

    la_capture_ctrl #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .abort     (abort),
        .sample_en (sample_en),
        .fire      (fire),
        .probe     (probe),
        .eff_len   (len_q),
        .rd_stb    (rd_stb),
        .state     (state),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign phase = state;

    p_cfg_locked_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && state != ST_IDLE) |=>
            ($stable(ctrl_q) && $stable(word_q) && $stable(mask_q) && $stable(len_q)));

endmodule

// File: tb/test_la_acq_top.sv
module test_la_acq_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int DEB = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          arm = 1'b0, abort = 1'b0;
    logic          ext_sclk = 1'b0, ext_trig = 1'b0, key_in = 1'b0, rd_stb = 1'b0;
    logic [DW-1:0] probe;
    logic [1:0]    phase;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    logic [31:0]   cyc = '0;
    logic          cnt_mode = 1'b0;
    logic [DW-1:0] man_val = '0;

    int checks = 0;
    int errors = 0;

    assign probe = cnt_mode ? cyc[DW-1:0] : man_val;

    la_acq_top #(.DATA_W(DW), .DEPTH(2048), .DEBOUNCE_CYCLES(DEB)) i_la_acq_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .arm(arm), .abort(abort), .probe(probe), .ext_sclk(ext_sclk), .ext_trig(ext_trig),
        .key_in(key_in), .rd_stb(rd_stb), .phase(phase), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cyc <= cyc + 32'd1;

    function automatic int exp_period(input int code);
        case (code)
            0: return 2000; 1: return 1000; 2: return 500; 3: return 200;
            4: return 100;  5: return 50;   6: return 10;  default: return 5;
        endcase
    endfunction

    function automatic int exp_len(input int raw);
        if (raw == 0) return 1;
        if (raw > 2048) return 2048;
        return raw;
    endfunction

    function automatic logic [DW-1:0] ctrl_word(input int rate, input bit ext, input int mode);
        return DW'((mode << 4) | (int'(ext) << 3) | rate);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    task automatic read_one(output logic v, output logic [DW-1:0] d);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic ext_pulse(input logic [DW-1:0] v);
        @(negedge clk); man_val = v;
        repeat (2) @(negedge clk);
        ext_sclk = 1'b1;
        repeat (4) @(negedge clk);
        ext_sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_phase(input logic [1:0] target, input int limit, output bit hit);
        hit = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (phase == target) begin hit = 1'b1; break; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic v;
        logic [DW-1:0] d, prev;
        bit hit;
        int n, bad, got;
        logic [DW-1:0] vals [8];

        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(phase == 2'd0, "R8 reset phase", phase, 0);
        check(rd_valid == 1'b0, "R10 reset valid", rd_valid, 0);

        // R2 R4 R10: every internal rate, probe advances every clock
        cnt_mode = 1'b1;
        for (int code = 0; code < 8; code++) begin
            n = 2 + int'($urandom % 3);
            cfg_write(2'd0, ctrl_word(code, 1'b0, 0));
            cfg_write(2'd3, DW'(n));
            pulse_arm();
            wait_phase(2'd3, 12000, hit);
            check(hit, "R4 clock trigger reaches DONE", phase, 3);
            bad = 0;
            for (int i = 0; i < n; i++) begin
                read_one(v, d);
                if (!v) bad++;
                if (i > 0 && DW'(d - prev) != DW'(exp_period(code))) bad++;
                prev = d;
            end
            check(bad == 0, "R2 sample spacing per rate code", bad, 0);
            read_one(v, d);
            check(v == 1'b0, "R10 no valid past stored count", v, 0);
            pulse_abort();
        end

        // R3: zero length acts as one
        cfg_write(2'd0, ctrl_word(7, 1'b0, 0));
        cfg_write(2'd3, 16'd0);
        pulse_arm();
        wait_phase(2'd3, 100, hit);
        check(hit, "R3 length 0 completes", phase, 3);
        read_one(v, d);
        check(v == 1'b1, "R3 length 0 stores one", v, 1);
        read_one(v, d);
        check(v == 1'b0, "R3 length 0 stores only one", v, 0);
        pulse_abort();

        // R3: oversize length clamps to the full buffer
        cfg_write(2'd3, 16'd3000);
        pulse_arm();
        wait_phase(2'd3, 12000, hit);
        check(hit, "R3 clamped capture completes", phase, 3);
        bad = 0; got = 0;
        for (int i = 0; i < 2048; i++) begin
            read_one(v, d);
            if (v) got++;
            if (i > 0 && DW'(d - prev) != DW'(5)) bad++;
            prev = d;
        end
        check(got == 2048, "R3 clamped count", got, 2048);
        check(bad == 0, "R3 clamped data order", bad, 0);
        read_one(v, d);
        check(v == 1'b0, "R3 nothing beyond 2048", v, 0);
        pulse_abort();

        // R1: external sample clock, internal divider ignored
        cnt_mode = 1'b0;
        cfg_write(2'd0, ctrl_word(7, 1'b1, 0));
        cfg_write(2'd3, 16'd5);
        pulse_arm();
        repeat (60) @(negedge clk);
        check(phase == 2'd1, "R1 internal rate ignored with ext clock", phase, 1);
        for (int i = 0; i < 5; i++) begin
            vals[i] = DW'($urandom);
            ext_pulse(vals[i]);
            if (i == 3) check(phase == 2'd2, "R8 capture in progress", phase, 2);
        end
        check(phase == 2'd3, "R1 five edges give five samples", phase, 3);
        pulse_arm();
        check(phase == 2'd3, "R8 arm ignored in DONE", phase, 3);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            read_one(v, d);
            if (!v || d != vals[i]) bad++;
        end
        check(bad == 0, "R1 ext samples in capture order", bad, 0);
        pulse_abort();
        check(phase == 2'd0, "R9 abort from DONE", phase, 0);

        // R6: word trigger on low byte 0x5A
        cfg_write(2'd0, ctrl_word(0, 1'b1, 2));
        cfg_write(2'd1, 16'h375A);
        cfg_write(2'd2, 16'h00FF);
        cfg_write(2'd3, 16'd3);
        pulse_arm();
        for (int i = 0; i < 3; i++) begin
            d = DW'($urandom);
            if (d[7:0] == 8'h5A) d[0] = ~d[0];
            ext_pulse(d);
        end
        check(phase == 2'd1, "R6 no trigger without match", phase, 1);
        vals[0] = {8'($urandom), 8'h5A};
        vals[1] = DW'($urandom);
        vals[2] = DW'($urandom);
        for (int i = 0; i < 3; i++) ext_pulse(vals[i]);
        check(phase == 2'd3, "R6 word capture done", phase, 3);
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            read_one(v, d);
            if (!v || d != vals[i]) bad++;
        end
        check(bad == 0, "R6 matching sample stored first", bad, 0);
        pulse_abort();

        // R5: external trigger
        cfg_write(2'd0, ctrl_word(0, 1'b1, 1));
        cfg_write(2'd3, 16'd2);
        pulse_arm();
        ext_pulse(16'h1111);
        ext_pulse(16'h2222);
        check(phase == 2'd1, "R5 waits for trigger edge", phase, 1);
        @(negedge clk); ext_trig = 1'b1;
        ext_pulse(16'hC0DE);
        ext_pulse(16'hBEEF);
        ext_trig = 1'b0;
        check(phase == 2'd3, "R5 capture after edge", phase, 3);
        read_one(v, d);
        check(v && d == 16'hC0DE, "R5 first sample after edge", d, 16'hC0DE);
        read_one(v, d);
        check(v && d == 16'hBEEF, "R5 second sample", d, 16'hBEEF);
        pulse_abort();

        // R7: key trigger with debounce
        cnt_mode = 1'b1;
        cfg_write(2'd0, ctrl_word(7, 1'b0, 3));
        cfg_write(2'd3, 16'd2);
        pulse_arm();
        @(negedge clk); key_in = 1'b1;
        repeat (5) @(negedge clk);
        key_in = 1'b0;
        repeat (60) @(negedge clk);
        check(phase == 2'd1, "R7 short pulse rejected", phase, 1);
        prev = cyc[DW-1:0];
        key_in = 1'b1;
        wait_phase(2'd3, 200, hit);
        key_in = 1'b0;
        check(hit, "R7 held press triggers", phase, 3);
        read_one(v, d);
        n = int'(DW'(d - prev));
        check(v && n >= DEB && n <= DEB + 12, "R7 trigger time after press", n, DEB);
        pulse_abort();

        // R11: writes while armed are ignored
        cnt_mode = 1'b0;
        cfg_write(2'd0, ctrl_word(0, 1'b1, 0));
        cfg_write(2'd3, 16'd3);
        pulse_arm();
        cfg_write(2'd3, 16'd1);
        cfg_write(2'd0, ctrl_word(7, 1'b0, 0));
        repeat (30) @(negedge clk);
        check(phase == 2'd1, "R11 source write ignored", phase, 1);
        ext_pulse(16'hA001);
        check(phase == 2'd2, "R11 length write ignored", phase, 2);
        pulse_abort();
        check(phase == 2'd0, "R9 abort from CAPTURE", phase, 0);
        read_one(v, d);
        check(v == 1'b0, "R10 no read outside DONE", v, 0);
        pulse_arm();
        pulse_abort();
        check(phase == 2'd0, "R9 abort from ARMED", phase, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule